// File: doc/BRIEF.md
# Sticky Reset-Source Status Register

This block keeps a record of which reset requests were behind the most recent reset cycle. Ten request lines come in, all synchronous to the register clock: two external service-request pins, the watchdog, software, power-on, on-chip debug, three debug/capture requests and a test reset. A read-only 32-bit status word on the bus shows one flag for each source. All other bits read as zero.

A reset cycle lasts as long as at least one request is asserted. During a cycle, every source that asserts sets its flag, and the flag holds until the cycle ends, so overlapping resets add up. The cycle ends when every request is low. The word then stays frozen, and a one-clock `cycle_done` pulse marks the point where it can be sampled. The first clock of the next cycle clears the old flags and loads the currently asserted sources in one step.

The flag for external pin 0 is qualified. A request on that pin only sets its flag when the pin's output configuration is open drain and its reset-control field selects reset generation.

Top module: `rst_source_status`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request asserted, `rd_data` equals 0x0001_0001 (the power-on and pin-0 flags).
- R2: Request index i maps to a status bit. Indices 0 and 1 (pin 0, pin 1) map to bits 0 and 1. Indices 2 and 3 (watchdog, software) map to bits 3 and 4. Indices 4 to 9 (power-on, on-chip debug, capture 0, capture 1, capture 3, test) map to bits 16 to 21.
- R3: Every bit of `rd_data` outside the ten flag positions always reads as zero.
- R4: While a cycle continues (some request is high on consecutive clocks), a flag that is set stays set, and each newly asserted source adds its flag.
- R5: On the first clock with any request high after a clock with all requests low, the flags are replaced by exactly the currently asserted (qualified) sources.
- R6: While all requests are low, `rd_data` does not change.
- R7: Request index 0 sets bit 0 only when `pin0_outcfg` is 4'hD or 4'hE and `pin0_rstctl` is 2'b01 or 2'b10. Under any other configuration it sets no flag, although it still starts and holds a cycle.
- R8: Bus writes (`wr_en` with any `wr_data`) have no effect on `rd_data`.
- R9: `cycle_done` is high for exactly one clock. That clock is the one after the first clock on which all requests are low following a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-up reset |
| req | input | 10 | Reset request lines, index order as in R2 |
| pin0_outcfg | input | 4 | Output configuration code of external pin 0 |
| pin0_rstctl | input | 2 | Reset-control field of external pin 0 |
| wr_en | input | 1 | Bus write strobe (ignored) |
| wr_data | input | 32 | Bus write data (ignored) |
| rd_data | output | 32 | Status word |
| cycle_done | output | 1 | One-clock pulse when a reset cycle ends |

## Verification
The assertions check these properties on every clock:
- reserved bits stay zero;
- set flags persist while a cycle continues;
- the word is frozen while the requests are idle, whether or not a write is presented;
- a rise of the pin-0 flag is always preceded by a qualifying configuration;
- `cycle_done` never lasts two clocks.

Only the bench scenarios can show the following:
- the exact bit map;
- the complete replacement of old flags at a fresh cycle;
- the result of all 64 pin-0 configuration combinations;
- the clock on which the done pulse appears.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int NUM_SRC = 10;
  localparam int WORD_W  = 32;
  localparam int CFG_W   = 4;
  localparam int CTL_W   = 2;

  // status bit position of request index i
  function automatic int src_pos(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 4;
      default: return i + 12;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] spread(input logic [NUM_SRC-1:0] v);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_SRC; i++) w[src_pos(i)] = v[i];
    return w;
  endfunction

  function automatic logic pin0_ok(input logic [CFG_W-1:0] cfg,
                                   input logic [CTL_W-1:0] ctl);
    return ((cfg == 4'hD) || (cfg == 4'hE)) && ((ctl == 2'b01) || (ctl == 2'b10));
  endfunction

  localparam logic [NUM_SRC-1:0] RESET_SRC  = NUM_SRC'(10'b00_0001_0001);
  localparam logic [WORD_W-1:0]  RESET_WORD = spread(RESET_SRC);
  localparam logic [WORD_W-1:0]  USED_MASK  = spread('1);
endpackage

// File: rtl/rss_qualify.sv
module rss_qualify
  import rss_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  input  logic [CFG_W-1:0]   cfg,
  input  logic [CTL_W-1:0]   ctl,
  output logic [NUM_SRC-1:0] req_q
);
  always_comb begin
    req_q    = req;
    req_q[0] = req[0] & pin0_ok(cfg, ctl);
  end
endmodule

// File: rtl/rss_cycle_track.sv
module rss_cycle_track
  import rss_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  output logic               req_any,
  output logic               cycle_start,
  output logic               cycle_done
);
  logic in_cycle;

  assign req_any     = |req;
  assign cycle_start = req_any & ~in_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cycle   <= 1'b0;
      cycle_done <= 1'b0;
    end else begin
      in_cycle   <= req_any;
      cycle_done <= in_cycle & ~req_any;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);
endmodule

// File: rtl/rss_flag_store.sv
module rss_flag_store
  import rss_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_q,
  input  logic               req_any,
  input  logic               cycle_start,
  output logic [WORD_W-1:0]  status
);
  logic [WORD_W-1:0] fresh;
  assign fresh = spread(req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           status <= RESET_WORD;
    else if (cycle_start) status <= fresh;
    else if (req_any)     status <= status | fresh;
  end

  // R4
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_any && !cycle_start) |=> ((status & $past(status)) == $past(status)));
  // R6
  idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_any |=> $stable(status));
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~USED_MASK) == '0);
endmodule

// File: rtl/rst_source_status.sv
module rst_source_status
  import rss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        req,
  input  logic [3:0]        pin0_outcfg,
  input  logic [1:0]        pin0_rstctl,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              cycle_done
);
  logic [NUM_SRC-1:0] req_q;
  logic               req_any;
  logic               cycle_start;
  logic               wr_touch;

  assign wr_touch = wr_en & (|wr_data | 1'b1);

  rss_qualify u_qual (
    .req   (req),
    .cfg   (pin0_outcfg),
    .ctl   (pin0_rstctl),
    .req_q (req_q)
  );

  rss_cycle_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .req_any     (req_any),
    .cycle_start (cycle_start),
    .cycle_done  (cycle_done)
  );

  rss_flag_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_q       (req_q),
    .req_any     (req_any),
    .cycle_start (cycle_start),
    .status      (rd_data)
  );

  // R8
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_touch && !req_any) |=> $stable(rd_data));
  // R7
  pin0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[0]) |-> $past(req[0] &&
      (pin0_outcfg == 4'hD || pin0_outcfg == 4'hE) &&
      (pin0_rstctl == 2'b01 || pin0_rstctl == 2'b10)));
endmodule

// File: tb/rst_source_status_bench.sv
`timescale 1ns/1ps
module rst_source_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  req = '0;
  logic [3:0]  cfg = 4'hD;
  logic [1:0]  ctl = 2'b01;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cycle_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rst_source_status u_rst_source_status (
    .clk(clk), .rst_n(rst_n), .req(req), .pin0_outcfg(cfg), .pin0_rstctl(ctl),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .cycle_done(cycle_done)
  );

  // expected position: indices 0..1 -> same, 2..3 -> +1, 4..9 -> +12
  function automatic logic [31:0] exp_word(input logic [9:0] v, input logic q0);
    logic [31:0] w = '0;
    for (int i = 0; i < 10; i++) begin
      int p = (i < 2) ? i : (i < 4) ? i + 1 : i + 12;
      if (v[i] && (i != 0 || q0)) w[p] = 1'b1;
    end
    return w;
  endfunction

  function automatic logic cfg_ok(input logic [3:0] c, input logic [1:0] k);
    return (c >= 4'd13 && c <= 4'd14) && (k != 2'd0 && k != 2'd3);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  // drive req at negedge, check after the following posedge
  task automatic apply(input logic [9:0] v); req = v; step(); endtask

  task automatic finish_cycle(input string tag);
    req = '0; step();
    check({tag, " done pulse"}, {31'b0, cycle_done}, 32'd1);
    step();
    check({tag, " done drop"}, {31'b0, cycle_done}, 32'd0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    @(negedge clk);
    check("R1 in reset", rd_data, 32'h0001_0001);
    step(); rst_n = 1'b1; step(); step();
    check("R1 after release", rd_data, 32'h0001_0001);
    check("R9 idle no pulse", {31'b0, cycle_done}, 32'd0);

    // R2 each source alone; also R5 replaces previous word
    for (int i = 0; i < 10; i++) begin
      apply(10'(1) << i);
      check($sformatf("R2/R5 src %0d", i), rd_data, exp_word(10'(1) << i, 1'b1));
      check("R3 reserved", rd_data & ~32'h003F_001B, 32'h0);
      finish_cycle("R9");
    end

    // R4 accumulation over overlapping requests
    apply(10'b00_0000_0100);
    apply(10'b00_0000_1100);
    apply(10'b00_0000_1000);
    apply(10'b10_0000_1000);
    check("R4 accumulate", rd_data, exp_word(10'b10_0000_1100, 1'b1));
    held = rd_data;
    finish_cycle("R9 accum");

    // R6 idle stability, R8 writes ignored
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; step();
    wr_data = 32'h0000_0000; step(); wr_en = 1'b0; step(); step();
    check("R6/R8 frozen", rd_data, held);

    // R5 new cycle loads current sources in one step
    apply(10'b01_0010_0000);
    check("R5 replace", rd_data, exp_word(10'b01_0010_0000, 1'b1));
    finish_cycle("R9 replace");

    // R7 sweep of pin-0 configuration, pin 0 alone
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        cfg = 4'(c); ctl = 2'(k);
        apply(10'b1);
        check($sformatf("R7 cfg %h ctl %0d", c, k), rd_data,
              exp_word(10'b1, cfg_ok(4'(c), 2'(k))));
        req = '0; step(); step();
      end
    end

    // R7 unqualified pin 0 still holds a cycle while another source accumulates
    cfg = 4'h9; ctl = 2'b01;
    apply(10'b00_0000_0011);
    apply(10'b00_0000_0001);
    check("R7 holds cycle", rd_data, exp_word(10'b00_0000_0010, 1'b0));
    finish_cycle("R9 pin0");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule